// File: doc/BRIEF.md
# SMBus Clock Timeout Detector

This block watches the already-filtered clock and data lines of a two-wire SMBus port and reports when the bus breaks one of its timing limits. The first detector measures a run of cycles without a break. A mode bit selects what it watches: either the clock line held low, or both lines held high, which is a bus idle condition. The second detector adds up the clock-low time that the local interface itself stretches during one message. The running total is cleared whenever a message start or stop is marked.

Either detector sets one shared sticky timeout flag. Software clears that flag with a one-cycle clear strobe. The flag is also gated by an error-interrupt enable to form an interrupt request. The limit fields and the mode bit can be written only while their detector is disabled. This keeps a running measurement from seeing its threshold change under it.

Top module: `smb_tmo_detect`

## Requirements
- R1: In clock-low mode (mode bit 0), the flag rises after the clock edge that samples the clock line low for the (LIMIT_A+1)·2^LOW_SHIFT-th consecutive cycle, and not one cycle earlier.
- R2: In idle mode (mode bit 1), the flag rises after (LIMIT_A+1)·2^IDLE_SHIFT consecutive cycles with both lines high. In this mode a low clock line never sets the flag.
- R3: Any cycle in which the watched condition is absent restarts the consecutive count from zero.
- R4: The stretch detector counts only cycles in which the local stretch input is high, and keeps its total across gaps. The flag rises on the (LIMIT_B+1)·2^LOW_SHIFT-th counted cycle.
- R5: A message start or message stop strobe clears the stretch total to zero.
- R6: On a configuration write, the two enables always update. LIMIT_A and the mode bit update only if the stored first enable is 0. LIMIT_B updates only if the stored stretch enable is 0.
- R7: A detector whose enable is 0 never sets the flag.
- R8: The flag stays set until the clear strobe. Each detection event sets it only once, so clearing it during a condition that persists leaves it clear. A detection in the same cycle as the clear strobe leaves the flag set.
- R9: The interrupt request equals the flag when the error-interrupt enable is 1, and is 0 otherwise.
- R10: After reset the flag, the interrupt request, both enables and both limits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Kernel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Filtered clock line |
| sda_i | input | 1 | Filtered data line |
| local_stretch_i | input | 1 | High while this interface holds the clock line low |
| msg_start_i | input | 1 | Start condition marker (one cycle) |
| msg_stop_i | input | 1 | Stop condition marker (one cycle) |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_lim_a_i | input | CFG_W | Limit for the clock-low / idle detector |
| cfg_idle_mode_i | input | 1 | 0 = clock-low timeout, 1 = bus idle detection |
| cfg_en_a_i | input | 1 | Enable for the clock-low / idle detector |
| cfg_lim_b_i | input | CFG_W | Limit for the cumulative stretch detector |
| cfg_en_b_i | input | 1 | Enable for the cumulative stretch detector |
| err_irq_en_i | input | 1 | Error interrupt enable |
| flag_clr_i | input | 1 | Timeout flag clear strobe |
| timeout_flag_o | output | 1 | Sticky timeout flag |
| err_irq_o | output | 1 | Error interrupt request |

## Verification
The bench uses a reduced configuration: a 4-bit limit, a clock-low scale of 8 and an idle scale of 2. This lets it sweep every limit value in both modes and probe one cycle below and exactly at each threshold, so an off-by-one or a wrong scale factor shows up directly. Broken runs, with a gap in the clock-low level or pauses in the stretch input, separate the restarting count from the accumulating one. Start and stop strobes placed in the middle of a stretch total show whether that total is cleared. Writes made while a detector is enabled, followed by timing measured at the ports, show whether a locked limit or mode was wrongly accepted.

// File: rtl/smb_tmo_pkg.sv
package smb_tmo_pkg;

   typedef enum logic {
      MODE_LOW  = 1'b0,
      MODE_IDLE = 1'b1
   } tmo_mode_e;

   function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/smb_tmo_cfg.sv
module smb_tmo_cfg
   import smb_tmo_pkg::*;
#(
   parameter int unsigned CFG_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_i,
   input  logic [CFG_W-1:0] lim_a_i,
   input  tmo_mode_e        mode_i,
   input  logic             en_a_i,
   input  logic [CFG_W-1:0] lim_b_i,
   input  logic             en_b_i,
   output logic [CFG_W-1:0] lim_a_o,
   output tmo_mode_e        mode_o,
   output logic             en_a_o,
   output logic [CFG_W-1:0] lim_b_o,
   output logic             en_b_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lim_a_o <= '0;
         mode_o  <= MODE_LOW;
         en_a_o  <= 1'b0;
         lim_b_o <= '0;
         en_b_o  <= 1'b0;
      end else if (wr_i) begin
         en_a_o <= en_a_i;
         en_b_o <= en_b_i;
         // fields are locked while their detector runs
         if (!en_a_o) begin
            lim_a_o <= lim_a_i;
            mode_o  <= mode_i;
         end
         if (!en_b_o) begin
            lim_b_o <= lim_b_i;
         end
      end
   end

endmodule

// File: rtl/smb_tmo_span.sv
module smb_tmo_span
   import smb_tmo_pkg::*;
#(
   parameter int unsigned CFG_W      = 12,
   parameter int unsigned LOW_SHIFT  = 11,
   parameter int unsigned IDLE_SHIFT = 2,
   parameter int unsigned CNT_W      = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             scl_i,
   input  logic             sda_i,
   input  logic             en_i,
   input  tmo_mode_e        mode_i,
   input  logic [CFG_W-1:0] lim_i,
   output logic             hit_o
);

   logic [CNT_W-1:0] base;
   logic [CNT_W-1:0] thr;
   logic [CNT_W-1:0] cnt;
   logic             cond;
   logic             active;

   assign base = CNT_W'(lim_i) + CNT_W'(1);

   // the scale factor depends on the watched condition
   always_comb begin
      if (mode_i == MODE_IDLE) begin
         thr  = base << IDLE_SHIFT;
         cond = scl_i & sda_i;
      end else begin
         thr  = base << LOW_SHIFT;
         cond = ~scl_i;
      end
   end

   assign active = en_i & cond;
   assign hit_o  = active & (cnt == thr - CNT_W'(1));

   // saturate at the threshold so one event gives one hit
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (!active) begin
         cnt <= '0;
      end else if (cnt != thr) begin
         cnt <= cnt + CNT_W'(1);
      end
   end

endmodule

// File: rtl/smb_tmo_accum.sv
module smb_tmo_accum #(
   parameter int unsigned CFG_W     = 12,
   parameter int unsigned LOW_SHIFT = 11,
   parameter int unsigned CNT_W     = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             stretch_i,
   input  logic             restart_i,
   input  logic             en_i,
   input  logic [CFG_W-1:0] lim_i,
   output logic             hit_o
);

   logic [CNT_W-1:0] thr;
   logic [CNT_W-1:0] cnt;
   logic             active;

   assign thr    = (CNT_W'(lim_i) + CNT_W'(1)) << LOW_SHIFT;
   assign active = en_i & stretch_i & ~restart_i;
   assign hit_o  = active & (cnt == thr - CNT_W'(1));

   // total held across pauses; cleared on message boundaries
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (restart_i || !en_i) begin
         cnt <= '0;
      end else if (stretch_i && (cnt != thr)) begin
         cnt <= cnt + CNT_W'(1);
      end
   end

endmodule

// File: rtl/smb_tmo_flag.sv
module smb_tmo_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic flag_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_o <= 1'b0;
      end else if (set_i) begin
         flag_o <= 1'b1;
      end else if (clr_i) begin
         flag_o <= 1'b0;
      end
   end

endmodule

// File: rtl/smb_tmo_detect.sv
module smb_tmo_detect
   import smb_tmo_pkg::*;
#(
   parameter int unsigned CFG_W      = 12,
   parameter int unsigned LOW_SHIFT  = 11,
   parameter int unsigned IDLE_SHIFT = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             scl_i,
   input  logic             sda_i,
   input  logic             local_stretch_i,
   input  logic             msg_start_i,
   input  logic             msg_stop_i,
   input  logic             cfg_wr_i,
   input  logic [CFG_W-1:0] cfg_lim_a_i,
   input  logic             cfg_idle_mode_i,
   input  logic             cfg_en_a_i,
   input  logic [CFG_W-1:0] cfg_lim_b_i,
   input  logic             cfg_en_b_i,
   input  logic             err_irq_en_i,
   input  logic             flag_clr_i,
   output logic             timeout_flag_o,
   output logic             err_irq_o
);

   localparam int unsigned MAX_SHIFT = max_u(LOW_SHIFT, IDLE_SHIFT);
   localparam int unsigned CNT_W     = CFG_W + MAX_SHIFT + 1;

   if (CFG_W < 1 || CFG_W > 16) begin : g_bad_cfg_w
      $error("CFG_W must lie in 1..16");
   end
   if (LOW_SHIFT > 16 || IDLE_SHIFT > 16) begin : g_bad_shift
      $error("scale shifts must not exceed 16");
   end

   logic [CFG_W-1:0] lim_a;
   logic [CFG_W-1:0] lim_b;
   tmo_mode_e        mode;
   logic             en_a;
   logic             en_b;
   logic             hit_a;
   logic             hit_b;
   logic             restart;

   assign restart = msg_start_i | msg_stop_i;

   smb_tmo_cfg #(.CFG_W(CFG_W)) u_cfg (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_i    (cfg_wr_i),
      .lim_a_i (cfg_lim_a_i),
      .mode_i  (tmo_mode_e'(cfg_idle_mode_i)),
      .en_a_i  (cfg_en_a_i),
      .lim_b_i (cfg_lim_b_i),
      .en_b_i  (cfg_en_b_i),
      .lim_a_o (lim_a),
      .mode_o  (mode),
      .en_a_o  (en_a),
      .lim_b_o (lim_b),
      .en_b_o  (en_b)
   );

   smb_tmo_span #(
      .CFG_W     (CFG_W),
      .LOW_SHIFT (LOW_SHIFT),
      .IDLE_SHIFT(IDLE_SHIFT),
      .CNT_W     (CNT_W)
   ) u_span (
      .clk    (clk),
      .rst_n  (rst_n),
      .scl_i  (scl_i),
      .sda_i  (sda_i),
      .en_i   (en_a),
      .mode_i (mode),
      .lim_i  (lim_a),
      .hit_o  (hit_a)
   );

   smb_tmo_accum #(
      .CFG_W    (CFG_W),
      .LOW_SHIFT(LOW_SHIFT),
      .CNT_W    (CNT_W)
   ) u_accum (
      .clk       (clk),
      .rst_n     (rst_n),
      .stretch_i (local_stretch_i),
      .restart_i (restart),
      .en_i      (en_b),
      .lim_i     (lim_b),
      .hit_o     (hit_b)
   );

   smb_tmo_flag u_flag (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (hit_a | hit_b),
      .clr_i  (flag_clr_i),
      .flag_o (timeout_flag_o)
   );

   assign err_irq_o = timeout_flag_o & err_irq_en_i;

endmodule

// File: rtl/smb_tmo_chk.sv
module smb_tmo_chk (
   input logic clk,
   input logic rst_n,
   input logic local_stretch_i,
   input logic msg_start_i,
   input logic msg_stop_i,
   input logic err_irq_en_i,
   input logic flag_clr_i,
   input logic timeout_flag_o,
   input logic err_irq_o,
   input logic en_a,
   input logic en_b,
   input logic hit_a,
   input logic hit_b
);

   assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (timeout_flag_o && !flag_clr_i) |=> timeout_flag_o);

   assert_clear_works_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_clr_i && !hit_a && !hit_b) |=> !timeout_flag_o);

   assert_rise_has_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(timeout_flag_o) |-> $past((hit_a && en_a) || (hit_b && en_b)));

   assert_irq_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !err_irq_en_i |-> !err_irq_o);

   assert_accum_only_stretch_R4: assert property (@(posedge clk) disable iff (!rst_n)
      hit_b |-> local_stretch_i);

   assert_restart_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_start_i || msg_stop_i) |-> !hit_b);

endmodule

bind smb_tmo_detect smb_tmo_chk u_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .local_stretch_i (local_stretch_i),
   .msg_start_i     (msg_start_i),
   .msg_stop_i      (msg_stop_i),
   .err_irq_en_i    (err_irq_en_i),
   .flag_clr_i      (flag_clr_i),
   .timeout_flag_o  (timeout_flag_o),
   .err_irq_o       (err_irq_o),
   .en_a            (en_a),
   .en_b            (en_b),
   .hit_a           (hit_a),
   .hit_b           (hit_b)
);

// File: tb/smb_tmo_detect_tb.sv
module smb_tmo_detect_tb;

   localparam int unsigned CFG_W      = 4;
   localparam int unsigned LOW_SHIFT  = 3;
   localparam int unsigned IDLE_SHIFT = 1;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             scl = 1'b1;
   logic             sda = 1'b0;
   logic             stretch = 1'b0;
   logic             m_start = 1'b0;
   logic             m_stop = 1'b0;
   logic             cfg_wr = 1'b0;
   logic [CFG_W-1:0] lim_a = '0;
   logic             idle_mode = 1'b0;
   logic             en_a = 1'b0;
   logic [CFG_W-1:0] lim_b = '0;
   logic             en_b = 1'b0;
   logic             irq_en = 1'b0;
   logic             clr = 1'b0;
   logic             flag;
   logic             irq;

   int n_chk  = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   smb_tmo_detect #(
      .CFG_W(CFG_W), .LOW_SHIFT(LOW_SHIFT), .IDLE_SHIFT(IDLE_SHIFT)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda),
      .local_stretch_i(stretch), .msg_start_i(m_start), .msg_stop_i(m_stop),
      .cfg_wr_i(cfg_wr), .cfg_lim_a_i(lim_a), .cfg_idle_mode_i(idle_mode),
      .cfg_en_a_i(en_a), .cfg_lim_b_i(lim_b), .cfg_en_b_i(en_b),
      .err_irq_en_i(irq_en), .flag_clr_i(clr),
      .timeout_flag_o(flag), .err_irq_o(irq)
   );

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input logic got, input logic exp, input string tag);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0b expected %0b", tag, got, exp);
      end
   endtask

   task automatic wcfg(input int a, input logic md, input logic ea,
                       input int b, input logic eb);
      lim_a = CFG_W'(a); idle_mode = md; en_a = ea;
      lim_b = CFG_W'(b); en_b = eb;
      cfg_wr = 1'b1;
      tick(1);
      cfg_wr = 1'b0;
   endtask

   task automatic clear_flag();
      clr = 1'b1;
      tick(1);
      clr = 1'b0;
   endtask

   task automatic pulse_start();
      m_start = 1'b1; tick(1); m_start = 1'b0;
   endtask

   task automatic pulse_stop();
      m_stop = 1'b1; tick(1); m_stop = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual running expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      tick(3);
      chk(flag, 1'b0, "R10 flag after reset");
      chk(irq, 1'b0, "R10 irq after reset");
      rst_n = 1'b1;
      tick(2);

      // R1 sweep over all limits, clock-low mode
      for (int a = 0; a < (1 << CFG_W); a++) begin
         int thr;
         thr = (a + 1) << LOW_SHIFT;
         wcfg(a, 1'b0, 1'b0, 0, 1'b0);
         wcfg(a, 1'b0, 1'b1, 0, 1'b0);
         scl = 1'b0;
         tick(thr - 1);
         chk(flag, 1'b0, "R1 below low threshold");
         tick(1);
         chk(flag, 1'b1, "R1 at low threshold");
         scl = 1'b1;
         clear_flag();
         chk(flag, 1'b0, "R8 cleared");
      end

      // R2 sweep, idle mode
      for (int a = 0; a < (1 << CFG_W); a++) begin
         int thr;
         thr = (a + 1) << IDLE_SHIFT;
         wcfg(a, 1'b1, 1'b0, 0, 1'b0);
         wcfg(a, 1'b1, 1'b1, 0, 1'b0);
         sda = 1'b1;
         tick(thr - 1);
         chk(flag, 1'b0, "R2 below idle threshold");
         tick(1);
         chk(flag, 1'b1, "R2 at idle threshold");
         sda = 1'b0;
         clear_flag();
      end
      // idle mode ignores a low clock
      scl = 1'b0;
      tick(300);
      chk(flag, 1'b0, "R2 low clock in idle mode");
      scl = 1'b1;

      // R3 restart on a gap (threshold 8)
      wcfg(0, 1'b0, 1'b0, 0, 1'b0);
      wcfg(0, 1'b0, 1'b1, 0, 1'b0);
      scl = 1'b0; tick(5);
      scl = 1'b1; tick(1);
      scl = 1'b0; tick(5);
      chk(flag, 1'b0, "R3 after gap");
      tick(2);
      chk(flag, 1'b0, "R3 seven after gap");
      tick(1);
      chk(flag, 1'b1, "R3 eight after gap");

      // R8 once per event, then set wins over clear
      clr = 1'b1; tick(1); clr = 1'b0;
      tick(20);
      chk(flag, 1'b0, "R8 no re-set on same event");
      scl = 1'b1; tick(1);
      scl = 1'b0; tick(7);
      clr = 1'b1; tick(1); clr = 1'b0;
      chk(flag, 1'b1, "R8 set wins over clear");
      scl = 1'b1; tick(10);
      chk(flag, 1'b1, "R8 sticky");

      // R9 interrupt gating
      chk(irq, 1'b0, "R9 irq disabled");
      irq_en = 1'b1; tick(1);
      chk(irq, 1'b1, "R9 irq enabled");
      clear_flag();
      chk(irq, 1'b0, "R9 irq after clear");

      // R6 locked fields for detector A (stored limit 0, low mode)
      wcfg(15, 1'b1, 1'b1, 0, 1'b0);
      scl = 1'b0; tick(8);
      chk(flag, 1'b1, "R6 locked limit and mode kept");
      scl = 1'b1; clear_flag();
      wcfg(15, 1'b0, 1'b0, 0, 1'b0);
      wcfg(15, 1'b0, 1'b1, 0, 1'b0);
      scl = 1'b0; tick(127);
      chk(flag, 1'b0, "R6 new limit below");
      tick(1);
      chk(flag, 1'b1, "R6 new limit at");
      scl = 1'b1; clear_flag();

      // R7 detector A disabled
      wcfg(0, 1'b0, 1'b0, 0, 1'b0);
      scl = 1'b0; tick(300);
      chk(flag, 1'b0, "R7 detector A disabled");
      scl = 1'b1; tick(1);

      // R4 cumulative stretch, threshold 16
      wcfg(0, 1'b0, 1'b0, 1, 1'b1);
      stretch = 1'b1; tick(10);
      stretch = 1'b0; tick(3);
      stretch = 1'b1; tick(5);
      chk(flag, 1'b0, "R4 fifteen stretched");
      tick(1);
      chk(flag, 1'b1, "R4 sixteen stretched");
      stretch = 1'b0; clear_flag();

      // R5 start and stop clear the total
      pulse_start();
      stretch = 1'b1; tick(10); stretch = 1'b0;
      pulse_stop();
      stretch = 1'b1; tick(15);
      chk(flag, 1'b0, "R5 total cleared by stop");
      tick(1);
      chk(flag, 1'b1, "R5 full count after stop");
      stretch = 1'b0; clear_flag();
      pulse_start();
      stretch = 1'b1; tick(12); stretch = 1'b0;
      pulse_start();
      stretch = 1'b1; tick(12);
      chk(flag, 1'b0, "R5 total cleared by start");
      stretch = 1'b0;
      pulse_stop();

      // R6 locked limit B (attempt to shrink to 8 ignored)
      wcfg(0, 1'b0, 1'b0, 0, 1'b1);
      stretch = 1'b1; tick(8);
      chk(flag, 1'b0, "R6 locked limit B");
      tick(8);
      chk(flag, 1'b1, "R6 limit B kept at 16");
      stretch = 1'b0; clear_flag();

      // R7 detector B disabled
      wcfg(0, 1'b0, 1'b0, 0, 1'b0);
      pulse_start();
      stretch = 1'b1; tick(200);
      chk(flag, 1'b0, "R7 detector B disabled");
      stretch = 1'b0;
      tick(2);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule